// File: doc/BRIEF.md
# Framer Error Counter Bank

This block keeps three performance-monitoring error counts for a T1/E1 framer and exposes them as bytes on a small read-only register bus. A 16-bit line-code counter tallies bipolar violations and, when enabled, excess-zeros events. A 10-bit far-end block error counter tallies remote block errors, but only while the framer runs in E1 mode. A 12-bit test-pattern bit error counter tallies pattern mismatches. The bit error count is read through a snapshot register.

Each counter has its own read side effect. Reading the high byte of the line-code count clears the whole count. Reading either byte of the far-end count clears the whole count. Both of these clears happen only while the hold-counts control is low. Reading the low byte of the bit error count captures the live count into a holding register and clears the live count. A later read of the high byte returns the held upper bits. All counters stop at all-ones. An event that arrives in the same cycle as a clearing read is kept, so the counter restarts at one.

Top module: `errcnt_bank`

## Requirements
- R1: After a synchronous active-low reset, all counts, the bit error holding register and `rd_data` are zero.
- R2: The line-code count increases by one in any cycle where `bpv_evt` is high, or where `exz_evt` and `exz_cnt_en` are both high. The increase is at most one per cycle, and `exz_evt` has no effect while `exz_cnt_en` is low. Offset 0x54 returns count bits 7:0 and has no side effect.
- R3: Offset 0x55 returns line-code count bits 15:8. The read zeroes the whole count when `latch_hold` is low, and leaves the count untouched when `latch_hold` is high.
- R4: The far-end count increases by one on `febe_evt` only while `e1_mode` is high. Offset 0x56 returns its bits 7:0. Offset 0x57 returns bits 9:8 in bits 1:0, with bits 7:2 always zero.
- R5: A read of offset 0x56 or 0x57 zeroes the whole far-end count when `latch_hold` is low. The count is unaffected when `latch_hold` is high.
- R6: A read of offset 0x58 returns bits 7:0 of the live bit error count. The same read copies all 12 bits into the holding register and zeroes the live count, whatever the value of `latch_hold`.
- R7: A read of offset 0x59 returns bits 11:8 of the holding register in bits 3:0, with bits 7:4 zero. This read changes no count.
- R8: Every counter stops at its all-ones value instead of wrapping.
- R9: When a clearing read coincides with an event for the same counter, the counter becomes one.
- R10: `rd_data` is registered. It shows the read value in the cycle after `rd_en`, and it is zero after any cycle without `rd_en`. A read of any other offset returns zero and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bpv_evt | input | 1 | Bipolar violation strobe, one cycle per event |
| exz_evt | input | 1 | Excess-zeros strobe |
| exz_cnt_en | input | 1 | Adds excess-zeros events to the line-code count |
| e1_mode | input | 1 | High in E1 mode; enables far-end counting |
| febe_evt | input | 1 | Far-end block error strobe |
| perr_evt | input | 1 | Test-pattern bit error strobe |
| latch_hold | input | 1 | When high, reads do not clear the line-code or far-end counts |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read offset |
| rd_data | output | 8 | Registered read data |

## Verification
Event strobes are counted at the rising edge that samples them. A read sampled at edge k returns the count as it stood before that edge: the value includes every event up to cycle k-1 and excludes the event of cycle k. That value appears on `rd_data` after edge k, and any side effect of the read takes effect at that same edge. The bench drives inputs at the falling edge and advances its reference model at the following rising edge. It compares `rd_data` at the next falling edge, so each expected byte is checked exactly one cycle after its strobe. Counter state is observed only through later reads.

// File: rtl/errcnt_pkg.sv
// Shared constants for the framer error counter bank.
// Assumes an 8-bit offset space; offsets are compared after a cast to the bus width.
package errcnt_pkg;
    localparam int unsigned OFS_LCV_LO  = 32'h54;
    localparam int unsigned OFS_LCV_HI  = 32'h55;
    localparam int unsigned OFS_FEBE_LO = 32'h56;
    localparam int unsigned OFS_FEBE_HI = 32'h57;
    localparam int unsigned OFS_BERR_LO = 32'h58;
    localparam int unsigned OFS_BERR_HI = 32'h59;

    // Decoded target of one read access.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LCV_LO,
        SEL_LCV_HI,
        SEL_FEBE_LO,
        SEL_FEBE_HI,
        SEL_BERR_LO,
        SEL_BERR_HI
    } rd_sel_e;
endpackage

// File: rtl/sat_counter.sv
// Saturating event counter with a synchronous clear.
// A clear that coincides with an event loads one, so the event is kept.
// Assumes W >= 1; the count stops at all-ones.
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = W'(1);

    // Count update: clear has priority, then saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? CNT_ONE : '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_ONE;
        end
    end
endmodule

// File: rtl/bit_err_snap.sv
// Test-pattern bit error counter with a snapshot holding register.
// On snap the live count is copied to the holding register and the live
// counter is cleared (restarting at one if an error arrives in that cycle).
module bit_err_snap #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         err_evt,
    input  logic         snap,
    output logic [W-1:0] live_cnt,
    output logic [W-1:0] held_cnt
);
    sat_counter #(.W(W)) u_live (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (err_evt),
        .clr  (snap),
        .cnt  (live_cnt)
    );

    // Holding register: captures the pre-clear live count on snap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_cnt <= '0;
        end else if (snap) begin
            held_cnt <= live_cnt;
        end
    end
endmodule

// File: rtl/reg_read_mux.sv
// Read decoder and registered data mux for the counter bank.
// Produces the per-counter read side-effect strobes in the strobe cycle and
// registers the selected byte for the following cycle.
// Assumes every count fits in two data bytes.
module reg_read_mux
    import errcnt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LCV_W  = 16,
    parameter int FEBE_W = 10,
    parameter int BERR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              latch_hold,
    input  logic [LCV_W-1:0]  lcv_cnt,
    input  logic [FEBE_W-1:0] febe_cnt,
    input  logic [BERR_W-1:0] berr_live,
    input  logic [BERR_W-1:0] berr_held,
    output logic              lcv_clr,
    output logic              febe_clr,
    output logic              berr_snap,
    output logic [DATA_W-1:0] rd_data
);
    localparam int VIEW_W = 2 * DATA_W;

    rd_sel_e            sel;
    logic [VIEW_W-1:0]  lcv_view;
    logic [VIEW_W-1:0]  febe_view;
    logic [VIEW_W-1:0]  live_view;
    logic [VIEW_W-1:0]  held_view;
    logic [DATA_W-1:0]  rd_next;

    // Offset decode into a one-of-seven selector.
    always_comb begin
        sel = SEL_NONE;
        if (rd_en) begin
            if (rd_addr == ADDR_W'(OFS_LCV_LO))       sel = SEL_LCV_LO;
            else if (rd_addr == ADDR_W'(OFS_LCV_HI))  sel = SEL_LCV_HI;
            else if (rd_addr == ADDR_W'(OFS_FEBE_LO)) sel = SEL_FEBE_LO;
            else if (rd_addr == ADDR_W'(OFS_FEBE_HI)) sel = SEL_FEBE_HI;
            else if (rd_addr == ADDR_W'(OFS_BERR_LO)) sel = SEL_BERR_LO;
            else if (rd_addr == ADDR_W'(OFS_BERR_HI)) sel = SEL_BERR_HI;
        end
    end

    // Zero-extend each count to a two-byte view.
    always_comb begin
        lcv_view  = '0;
        febe_view = '0;
        live_view = '0;
        held_view = '0;
        lcv_view[LCV_W-1:0]   = lcv_cnt;
        febe_view[FEBE_W-1:0] = febe_cnt;
        live_view[BERR_W-1:0] = berr_live;
        held_view[BERR_W-1:0] = berr_held;
    end

    // Byte select for the addressed register.
    always_comb begin
        unique case (sel)
            SEL_LCV_LO:  rd_next = lcv_view[DATA_W-1:0];
            SEL_LCV_HI:  rd_next = lcv_view[VIEW_W-1:DATA_W];
            SEL_FEBE_LO: rd_next = febe_view[DATA_W-1:0];
            SEL_FEBE_HI: rd_next = febe_view[VIEW_W-1:DATA_W];
            SEL_BERR_LO: rd_next = live_view[DATA_W-1:0];
            SEL_BERR_HI: rd_next = held_view[VIEW_W-1:DATA_W];
            default:     rd_next = '0;
        endcase
    end

    // Read side effects for each counter.
    always_comb begin
        lcv_clr   = (sel == SEL_LCV_HI) && !latch_hold;
        febe_clr  = ((sel == SEL_FEBE_LO) || (sel == SEL_FEBE_HI)) && !latch_hold;
        berr_snap = (sel == SEL_BERR_LO);
    end

    // Output register: read data appears one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/errcnt_bank.sv
// Framer error counter bank: line-code, far-end block and bit error counts
// behind a byte-wide read bus with per-counter read side effects.
// Assumes single-cycle event strobes synchronous to clk.
module errcnt_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LCV_W  = 16,
    parameter int FEBE_W = 10,
    parameter int BERR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bpv_evt,
    input  logic              exz_evt,
    input  logic              exz_cnt_en,
    input  logic              e1_mode,
    input  logic              febe_evt,
    input  logic              perr_evt,
    input  logic              latch_hold,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              lcv_inc;
    logic              febe_inc;
    logic              lcv_clr;
    logic              febe_clr;
    logic              berr_snap;
    logic [LCV_W-1:0]  lcv_q;
    logic [FEBE_W-1:0] febe_q;
    logic [BERR_W-1:0] berr_q;
    logic [BERR_W-1:0] berr_hold;

    // Event qualification by the enable and mode inputs.
    always_comb begin
        lcv_inc  = bpv_evt | (exz_evt & exz_cnt_en);
        febe_inc = febe_evt & e1_mode;
    end

    sat_counter #(.W(LCV_W)) u_lcv (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (lcv_inc),
        .clr  (lcv_clr),
        .cnt  (lcv_q)
    );

    sat_counter #(.W(FEBE_W)) u_febe (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (febe_inc),
        .clr  (febe_clr),
        .cnt  (febe_q)
    );

    bit_err_snap #(.W(BERR_W)) u_berr (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_evt (perr_evt),
        .snap    (berr_snap),
        .live_cnt(berr_q),
        .held_cnt(berr_hold)
    );

    reg_read_mux #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LCV_W (LCV_W),
        .FEBE_W(FEBE_W),
        .BERR_W(BERR_W)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .latch_hold(latch_hold),
        .lcv_cnt   (lcv_q),
        .febe_cnt  (febe_q),
        .berr_live (berr_q),
        .berr_held (berr_hold),
        .lcv_clr   (lcv_clr),
        .febe_clr  (febe_clr),
        .berr_snap (berr_snap),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/errcnt_bank_chk.sv
// Property checker for the error counter bank, bound onto the top module.
// Observes ports and the internal count registers.
module errcnt_bank_chk
    import errcnt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LCV_W  = 16,
    parameter int FEBE_W = 10,
    parameter int BERR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bpv_evt,
    input logic              exz_evt,
    input logic              exz_cnt_en,
    input logic              e1_mode,
    input logic              febe_evt,
    input logic              perr_evt,
    input logic              latch_hold,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [LCV_W-1:0]  lcv_q,
    input logic [FEBE_W-1:0] febe_q,
    input logic [BERR_W-1:0] berr_q
);
    logic rd_lcv_hi, rd_febe, rd_berr_lo, rd_berr_hi, rd_febe_hi;

    always_comb begin
        rd_lcv_hi  = rd_en && (rd_addr == ADDR_W'(OFS_LCV_HI));
        rd_febe_hi = rd_en && (rd_addr == ADDR_W'(OFS_FEBE_HI));
        rd_febe    = rd_febe_hi || (rd_en && (rd_addr == ADDR_W'(OFS_FEBE_LO)));
        rd_berr_lo = rd_en && (rd_addr == ADDR_W'(OFS_BERR_LO));
        rd_berr_hi = rd_en && (rd_addr == ADDR_W'(OFS_BERR_HI));
    end

    // R10
    idle_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    // R4
    febe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(e1_mode && febe_evt) && !(rd_febe && !latch_hold)) |=> $stable(febe_q));

    // R4
    febe_hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_febe_hi |=> (rd_data[DATA_W-1:FEBE_W-DATA_W] == '0));

    // R3
    lcv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lcv_hi && latch_hold && !bpv_evt && !(exz_evt && exz_cnt_en)) |=> $stable(lcv_q));

    // R8
    lcv_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lcv_q == {LCV_W{1'b1}}) && !(rd_lcv_hi && !latch_hold)) |=> (lcv_q == {LCV_W{1'b1}}));

    // R6
    berr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_berr_lo && !perr_evt) |=> (berr_q == '0));

    // R7
    berr_hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_berr_hi |=> (rd_data[DATA_W-1:BERR_W-DATA_W] == '0));

    // R9
    lcv_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lcv_hi && !latch_hold && bpv_evt) |=> (lcv_q == LCV_W'(1)));
endmodule

bind errcnt_bank errcnt_bank_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LCV_W (LCV_W),
    .FEBE_W(FEBE_W),
    .BERR_W(BERR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bpv_evt   (bpv_evt),
    .exz_evt   (exz_evt),
    .exz_cnt_en(exz_cnt_en),
    .e1_mode   (e1_mode),
    .febe_evt  (febe_evt),
    .perr_evt  (perr_evt),
    .latch_hold(latch_hold),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .lcv_q     (lcv_q),
    .febe_q    (febe_q),
    .berr_q    (berr_q)
);

// File: tb/errcnt_bank_bench.sv
`timescale 1ns/1ps
// Self-checking bench: reference model in bench functions, seeded random
// traffic plus directed saturation, coincidence and mode cases.
module errcnt_bank_bench;
    localparam int LCV_MAX  = 65535;
    localparam int FEBE_MAX = 1023;
    localparam int BERR_MAX = 4095;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bpv_evt = 1'b0, exz_evt = 1'b0, exz_cnt_en = 1'b0, e1_mode = 1'b0;
    logic       febe_evt = 1'b0, perr_evt = 1'b0, latch_hold = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int m_lcv = 0, m_febe = 0, m_berr = 0, m_hold = 0;

    errcnt_bank u_errcnt_bank (
        .clk(clk), .rst_n(rst_n), .bpv_evt(bpv_evt), .exz_evt(exz_evt),
        .exz_cnt_en(exz_cnt_en), .e1_mode(e1_mode), .febe_evt(febe_evt),
        .perr_evt(perr_evt), .latch_hold(latch_hold), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    function automatic int step(int v, bit clr, bit inc, int vmax);
        if (clr) return inc ? 1 : 0;
        if (inc && v < vmax) return v + 1;
        return v;
    endfunction

    function automatic int read_val(logic [7:0] a);
        case (a)
            8'h54: return m_lcv & 255;
            8'h55: return (m_lcv >> 8) & 255;
            8'h56: return m_febe & 255;
            8'h57: return (m_febe >> 8) & 3;
            8'h58: return m_berr & 255;
            8'h59: return (m_hold >> 8) & 15;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h54: return "R2/R8";
            8'h55: return "R3/R9";
            8'h56: return "R4/R5";
            8'h57: return "R4/R5";
            8'h58: return "R6";
            8'h59: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: model advances at the rising edge, output checked at the falling edge.
    task automatic cyc();
        int    exp;
        string tg;
        bit    lclr, fclr, snap;
        @(posedge clk);
        exp  = rd_en ? read_val(rd_addr) : 0;
        tg   = rd_en ? tag_of(rd_addr) : "R10";
        lclr = rd_en && rd_addr == 8'h55 && !latch_hold;
        fclr = rd_en && (rd_addr == 8'h56 || rd_addr == 8'h57) && !latch_hold;
        snap = rd_en && rd_addr == 8'h58;
        if (snap) m_hold = m_berr;
        m_lcv  = step(m_lcv, lclr, bpv_evt | (exz_evt & exz_cnt_en), LCV_MAX);
        m_febe = step(m_febe, fclr, febe_evt & e1_mode, FEBE_MAX);
        m_berr = step(m_berr, snap, perr_evt, BERR_MAX);
        @(negedge clk);
        chk(tg, int'(rd_data), exp);
    endtask

    task automatic idle_inputs();
        bpv_evt = 0; exz_evt = 0; febe_evt = 0; perr_evt = 0; rd_en = 0;
    endtask

    task automatic rd(logic [7:0] a);
        rd_en = 1; rd_addr = a;
        cyc();
        rd_en = 0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state seen through every register
        chk("R1 rd_data", int'(rd_data), 0);
        for (int a = 8'h54; a <= 8'h59; a++) rd(8'(a));

        // R2: excess-zeros ignored while disabled, counted when enabled; both in one cycle count once
        exz_evt = 1; exz_cnt_en = 0; repeat (5) cyc();
        exz_cnt_en = 1; repeat (3) cyc();
        bpv_evt = 1; repeat (2) cyc();
        idle_inputs(); exz_cnt_en = 0;
        rd(8'h54);

        // R3: hold-counts high keeps the line-code count, low clears it
        latch_hold = 1; rd(8'h55); rd(8'h54);
        latch_hold = 0; rd(8'h55); rd(8'h54);

        // R9: event in the same cycle as the clearing read restarts at one
        bpv_evt = 1; repeat (4) cyc();
        rd_en = 1; rd_addr = 8'h55; cyc(); idle_inputs(); rd(8'h54);

        // R4/R5: far-end counting gated by mode; either byte clears
        febe_evt = 1; e1_mode = 0; repeat (6) cyc();
        e1_mode = 1; repeat (7) cyc(); idle_inputs();
        rd(8'h56); rd(8'h56);
        febe_evt = 1; repeat (3) cyc(); idle_inputs();
        rd(8'h57); rd(8'h56);

        // R6/R7: snapshot, clear, held upper bits
        perr_evt = 1; repeat (300) cyc(); idle_inputs();
        rd(8'h59); rd(8'h58); rd(8'h59); rd(8'h58); rd(8'h59);

        // R8: saturation of every counter
        bpv_evt = 1; febe_evt = 1; perr_evt = 1;
        repeat (65600) cyc(); idle_inputs();
        rd(8'h54); rd(8'h59); rd(8'h58); rd(8'h59);
        latch_hold = 1; rd(8'h55); rd(8'h56); rd(8'h57);
        latch_hold = 0;

        // R10: unmapped offsets return zero and disturb nothing
        rd(8'h00); rd(8'h53); rd(8'h5a); rd(8'hff);
        rd(8'h57); rd(8'h55);

        // Seeded random traffic across all inputs
        for (int i = 0; i < 20000; i++) begin
            int r;
            bpv_evt    = ($urandom % 4) == 0;
            exz_evt    = ($urandom % 4) == 0;
            exz_cnt_en = ($urandom % 2) == 0;
            e1_mode    = ($urandom % 4) != 0;
            febe_evt   = ($urandom % 4) == 0;
            perr_evt   = ($urandom % 3) == 0;
            latch_hold = ($urandom % 4) == 0;
            rd_en      = ($urandom % 4) == 0;
            r = $urandom % 8;
            rd_addr = (r < 6) ? 8'(8'h54 + r) : 8'($urandom);
            cyc();
        end
        idle_inputs();
        cyc();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule